// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Event Latching

This block groups general-purpose pins into banks of up to 32 lines. Software reaches each bank through eight 32-bit registers on a plain read/write port. Those registers set which lines are outputs, what each output drives, and whether an output is push-pull or open-drain. They also set how each input line raises an event, and they hold the latched event status.

Input pins pass through a two-flop synchroniser. The synchronised value is then compared with its value from the previous cycle. A small decoder turns the three per-line configuration bits into one of five trigger modes:
- `TRIG_LOW`: level, active low.
- `TRIG_HIGH`: level, active high.
- `TRIG_FALL`: falling edge.
- `TRIG_RISE`: rising edge.
- `TRIG_BOTH`: either edge.

Each line follows one transition, from "no event" to "latched". A trigger hit takes it there. A write of one to its status bit returns it to "no event", unless the hit is still present. Every bank ANDs its status with its mask. The results of all banks are ORed into one interrupt line.

Banks may be narrower than 32 lines, and a bank may have no lines at all. The unused bit positions stay zero in every register.

Top module: `gpio_multibank`

## Requirements
- R1: Bank b occupies byte addresses b*32 to b*32+31, one register every 4 bytes. Register index = (address/4) mod 8, with this index assignment:
  - 0: open-drain enable
  - 1: data
  - 2: direction
  - 3: polarity/edge select
  - 4: both-edges enable
  - 5: mask
  - 6: level select
  - 7: status

  A read strobe returns the addressed register on `bus_rdata` after the next rising clock edge, and the value holds until the next read. Addresses past the last bank read zero. Writing one register leaves the others unchanged.
- R2: After reset every register reads zero, except direction, which reads ones on every implemented line (all inputs). `irq` is 0 and no pad is driven.
- R3: With a bank width of W:
  - Register bits W..31 read zero, never latch status and never drive a pad.
  - A width-0 bank reads zero everywhere.
  - Pin activity on unimplemented positions has no effect.
- R4: Reading the data register returns the stored data bit on output lines (direction 0) and the synchronised pin on input lines (direction 1).
- R5: With level select 1, a line latches status on every cycle its synchronised pin equals its polarity bit (1 = high, 0 = low). A clear written while the condition holds leaves the bit set.
- R6: With level select 0 and both-edges 0, polarity 1 latches on a rising edge of the synchronised pin and polarity 0 latches on a falling edge. The opposite edge has no effect.
- R7: With level select 0 and both-edges 1, either edge latches status, whatever the polarity bit holds.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it. A trigger hit in the same cycle as a clear wins.
- R9: `irq` is 1 exactly when some bank has a bit set in both status and mask. A masked-off line still latches status.
- R10: A pin change applied between clock edges latches status at the third rising edge after it. `irq` reflects it from then on.
- R11: For a line with direction 0:
  - With open-drain 0, `pad_oe` is 1 and `pad_out` follows data.
  - With open-drain 1, `pad_oe` is 1 and `pad_out` is 0 when data is 0. When data is 1, `pad_oe` is 0.

  Lines with direction 1 have `pad_oe` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address (bank in upper bits, register index in bits 4:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_BANKS*32 | Pad input levels, bank b on bits b*32 and up |
| pad_out | output | NUM_BANKS*32 | Pad output value |
| pad_oe | output | NUM_BANKS*32 | Pad output enable |
| irq | output | 1 | Combined interrupt for all banks |

## Verification
A corrupted synchroniser or edge-history flop shows up as a status bit latched one cycle early or late, or as a spurious or missing latch. It becomes visible at `irq` on the cycle after the bad value, when the line is unmasked, and through a status read otherwise. A configuration register holding a wrong value changes the trigger mode silently, and it is exposed only when a pin on that line moves. For that reason the bench drives every trigger mode on its own line while a cycle-level model tracks the whole register set. A wrong direction or open-drain bit appears immediately on `pad_oe` and `pad_out`, which are compared on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int REGS_PER_BANK  = 8;
    localparam int IDX_W          = $clog2(REGS_PER_BANK);

    // Register index within a bank; the order is the address map.
    typedef enum logic [IDX_W-1:0] {
        REG_ODRAIN   = 3'd0,
        REG_DATA     = 3'd1,
        REG_DIR      = 3'd2,
        REG_POLARITY = 3'd3,
        REG_ANYEDGE  = 3'd4,
        REG_MASK     = 3'd5,
        REG_LEVEL    = 3'd6,
        REG_STATUS   = 3'd7
    } gpio_reg_e;

    // Per-line trigger mode decoded from three configuration bits.
    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_LOW  = 3'd3,
        TRIG_HIGH = 3'd4
    } gpio_trig_e;

    function automatic gpio_trig_e trig_of(input logic lvl, input logic pol, input logic any);
        if (lvl)      return pol ? TRIG_HIGH : TRIG_LOW;
        else if (any) return TRIG_BOTH;
        else          return pol ? TRIG_RISE : TRIG_FALL;
    endfunction

    function automatic logic [LINES_PER_BANK-1:0] line_mask(input int width);
        if (width >= LINES_PER_BANK) return '1;
        return (LINES_PER_BANK'(1) << width) - LINES_PER_BANK'(1);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] both_i,
    output logic [W-1:0] evt_o
);

    for (genvar i = 0; i < W; i++) begin : g_line
        gpio_trig_e mode;
        logic       hit;

        always_comb begin
            mode = trig_of(level_i[i], pol_i[i], both_i[i]);
            unique case (mode)
                TRIG_LOW:  hit = ~cur_i[i];
                TRIG_HIGH: hit = cur_i[i];
                TRIG_RISE: hit = cur_i[i] & ~prev_i[i];
                TRIG_FALL: hit = ~cur_i[i] & prev_i[i];
                TRIG_BOTH: hit = cur_i[i] ^ prev_i[i];
                default:   hit = 1'b0;
            endcase
        end

        assign evt_o[i] = hit;
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int LW = LINES_PER_BANK,
    localparam logic [LINES_PER_BANK-1:0] IMPL = line_mask(WIDTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  gpio_reg_e     wr_idx,
    input  logic [31:0]   wr_data,
    input  gpio_reg_e     rd_idx,
    output logic [31:0]   rd_data,
    input  logic [LW-1:0] pin_i,
    output logic [LW-1:0] pad_out_o,
    output logic [LW-1:0] pad_oe_o,
    output logic [LW-1:0] evt_o,
    output logic [LW-1:0] status_o,
    output logic [LW-1:0] impl_o,
    output logic          pending_o
);

    logic [LW-1:0] odrain_q, data_q, dir_q, pol_q, any_q, mask_q, level_q, status_q;
    logic [LW-1:0] sync_v, prev_v, evt_raw, evt, clr;

    // Input path: variant chosen by bank width
    if (WIDTH == 0) begin : g_empty
        assign sync_v  = '0;
        assign prev_v  = '0;
        assign evt_raw = '0;
    end else begin : g_live
        gpio_sync #(.W(LW)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_i & IMPL),
            .sync_o  (sync_v),
            .prev_o  (prev_v)
        );

        gpio_evt_detect #(.W(LW)) u_det (
            .cur_i   (sync_v),
            .prev_i  (prev_v),
            .level_i (level_q),
            .pol_i   (pol_q),
            .both_i  (any_q),
            .evt_o   (evt_raw)
        );
    end

    assign evt = evt_raw & IMPL;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odrain_q <= '0;
            data_q   <= '0;
            dir_q    <= IMPL;
            pol_q    <= '0;
            any_q    <= '0;
            mask_q   <= '0;
            level_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                REG_ODRAIN:   odrain_q <= wr_data & IMPL;
                REG_DATA:     data_q   <= wr_data & IMPL;
                REG_DIR:      dir_q    <= wr_data & IMPL;
                REG_POLARITY: pol_q    <= wr_data & IMPL;
                REG_ANYEDGE:  any_q    <= wr_data & IMPL;
                REG_MASK:     mask_q   <= wr_data & IMPL;
                REG_LEVEL:    level_q  <= wr_data & IMPL;
                REG_STATUS:   ;
            endcase
        end
    end

    // Status: write-one-to-clear, a new hit overrides the clear
    assign clr = (wr_en && wr_idx == REG_STATUS) ? wr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | evt;
    end

    // Read mux
    always_comb begin
        unique case (rd_idx)
            REG_ODRAIN:   rd_data = odrain_q;
            REG_DATA:     rd_data = (data_q & ~dir_q) | (sync_v & dir_q & IMPL);
            REG_DIR:      rd_data = dir_q;
            REG_POLARITY: rd_data = pol_q;
            REG_ANYEDGE:  rd_data = any_q;
            REG_MASK:     rd_data = mask_q;
            REG_LEVEL:    rd_data = level_q;
            REG_STATUS:   rd_data = status_q;
        endcase
    end

    // Pad drive
    assign pad_oe_o  = ~dir_q & ~(odrain_q & data_q) & IMPL;
    assign pad_out_o = data_q & ~odrain_q & IMPL;

    assign evt_o     = evt;
    assign status_o  = status_q;
    assign impl_o    = IMPL;
    assign pending_o = |(status_q & mask_q);

endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd12, 6'd0, 6'd32},
    localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W = BANK_BITS + 5,
    localparam int LINES = NUM_BANKS * LINES_PER_BANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    output logic              irq
);

    logic [BANK_BITS-1:0] bank_sel;
    gpio_reg_e            reg_idx;
    logic [31:0]          bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_pend;
    logic [LINES-1:0]     evt_all, stat_all, impl_all;
    logic [31:0]          rd_mux;
    logic [31:0]          rdata_q;

    assign bank_sel = bus_addr[ADDR_W-1:5];
    assign reg_idx  = gpio_reg_e'(bus_addr[4:2]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.WIDTH(int'(BANK_WIDTHS[b*6 +: 6]))) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_we && (bank_sel == BANK_BITS'(b))),
            .wr_idx    (reg_idx),
            .wr_data   (bus_wdata),
            .rd_idx    (reg_idx),
            .rd_data   (bank_rd[b]),
            .pin_i     (pin_in[b*32 +: 32]),
            .pad_out_o (pad_out[b*32 +: 32]),
            .pad_oe_o  (pad_oe[b*32 +: 32]),
            .evt_o     (evt_all[b*32 +: 32]),
            .status_o  (stat_all[b*32 +: 32]),
            .impl_o    (impl_all[b*32 +: 32]),
            .pending_o (bank_pend[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BANK_BITS'(b)) rd_mux = bank_rd[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |bank_pend;

endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk #(
    parameter int NUM_BANKS = 3,
    localparam int LINES = NUM_BANKS * 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             irq,
    input logic [LINES-1:0] pad_oe,
    input logic [LINES-1:0] evt_all,
    input logic [LINES-1:0] stat_all,
    input logic [LINES-1:0] impl_all
);

    AST_RESET_PADS_RELEASED: assert property (@(posedge clk) !rst_n |=> (pad_oe == '0)); // R2

    AST_NO_GHOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_all & ~impl_all) == '0); // R3

    AST_NO_GHOST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all & ~impl_all) == '0); // R3

    AST_NO_GHOST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~impl_all) == '0); // R11

    AST_STATUS_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all & ~$past(stat_all) & ~$past(evt_all)) == '0); // R6

    AST_IRQ_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_we)); // R8

    AST_IRQ_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bus_we) || $past(|evt_all))); // R9

endmodule

bind gpio_multibank gpio_multibank_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/test_gpio_multibank.sv
`timescale 1ns/1ps
module test_gpio_multibank;

    localparam int NB = 3;
    localparam int TW = NB * 32;
    localparam int AW = 7;
    localparam int WIDTHS [NB] = '{32, 0, 12};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [TW-1:0] pins = '0;
    logic [TW-1:0] pad_out, pad_oe;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_multibank #(.NUM_BANKS(NB), .BANK_WIDTHS({6'd12, 6'd0, 6'd32})) i_gpio_multibank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pins), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] mr [NB][8];
    logic [31:0] s1 [NB];
    logic [31:0] s2 [NB];
    logic [31:0] pv [NB];
    logic [31:0] m_rdata;
    logic        m_live = 1'b0;

    function automatic logic [31:0] impl_of(int b);
        longint w = WIDTHS[b];
        if (w >= 32) return 32'hFFFF_FFFF;
        return 32'(((64'd1) << w) - 1);
    endfunction

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        int b = int'(a) / 32;
        int ix = (int'(a) / 4) % 8;
        if (b >= NB) return 32'h0;
        if (ix == 1) return (mr[b][1] & ~mr[b][2]) | (s2[b] & mr[b][2] & impl_of(b));
        return mr[b][ix];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                for (int r = 0; r < 8; r++) mr[b][r] = 32'h0;
                mr[b][2] = impl_of(b);
                s1[b] = 0; s2[b] = 0; pv[b] = 0;
            end
            m_rdata = 0;
            m_live = 1'b0;
        end else begin
            if (bus_re) m_rdata = m_read(bus_addr);
            for (int b = 0; b < NB; b++) begin
                logic [31:0] ev;
                logic [31:0] clr;
                int ix;
                ev = 0;
                for (int k = 0; k < 32; k++) begin
                    logic c, p, e;
                    c = s2[b][k]; p = pv[b][k];
                    if (mr[b][6][k])      e = mr[b][3][k] ? c : !c;
                    else if (mr[b][4][k]) e = (c != p);
                    else if (mr[b][3][k]) e = c && !p;
                    else                  e = !c && p;
                    ev[k] = e && impl_of(b)[k];
                end
                ix = (int'(bus_addr) / 4) % 8;
                clr = 0;
                if (bus_we && int'(bus_addr) / 32 == b) begin
                    if (ix == 7) clr = bus_wdata;
                    else mr[b][ix] = bus_wdata & impl_of(b);
                end
                mr[b][7] = (mr[b][7] & ~clr) | ev;
                pv[b] = s2[b];
                s2[b] = s1[b];
                s1[b] = pins[b*32 +: 32] & impl_of(b);
            end
            m_live = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live) begin
            logic m_irq;
            logic [TW-1:0] m_oe, m_out;
            m_irq = 0;
            for (int b = 0; b < NB; b++) begin
                m_irq |= |(mr[b][7] & mr[b][5]);
                m_oe[b*32 +: 32]  = ~mr[b][2] & ~(mr[b][0] & mr[b][1]) & impl_of(b);
                m_out[b*32 +: 32] = mr[b][1] & ~mr[b][0] & impl_of(b);
            end
            n_cmp += 4;
            if (bus_rdata !== m_rdata) begin
                n_bad++; $display("FAIL R1 model rdata actual=%h expected=%h", bus_rdata, m_rdata);
            end
            if (irq !== m_irq) begin
                n_bad++; $display("FAIL R9 model irq actual=%b expected=%b", irq, m_irq);
            end
            if (pad_oe !== m_oe) begin
                n_bad++; $display("FAIL R11 model pad_oe actual=%h expected=%h", pad_oe, m_oe);
            end
            if (pad_out !== m_out) begin
                n_bad++; $display("FAIL R11 model pad_out actual=%h expected=%h", pad_out, m_out);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_re = 1'b1; bus_addr = AW'(a);
        @(negedge clk); #1;
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    function automatic int A(input int b, input int ix);
        return b * 32 + ix * 4;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R2 / R3 reset state
        chk("R2 irq after reset", {31'h0, irq}, 32'h0);
        rd(A(0,2), v); chk("R2 bank0 direction", v, 32'hFFFF_FFFF);
        rd(A(2,2), v); chk("R3 bank2 direction width 12", v, 32'h0000_0FFF);
        rd(A(1,2), v); chk("R3 empty bank direction", v, 32'h0);
        rd(A(0,7), v); chk("R2 status after reset", v, 32'h0);

        // R1 map, R3 unused bits
        wr(A(2,5), 32'h0000_0ABC); rd(A(2,5), v); chk("R1 mask readback", v, 32'h0000_0ABC);
        wr(A(2,5), 32'hFFFF_FFFF); rd(A(2,5), v); chk("R3 upper bits zero", v, 32'h0000_0FFF);
        wr(A(2,5), 32'h0);
        wr(A(1,5), 32'hFFFF_FFFF); rd(A(1,5), v); chk("R3 empty bank write", v, 32'h0);
        rd(100, v); chk("R1 unmapped bank", v, 32'h0);
        wr(A(0,3), 32'h55); rd(A(0,4), v); chk("R1 neighbour untouched", v, 32'h0);
        rd(A(0,3), v); chk("R1 polarity readback", v, 32'h55);
        wr(A(0,3), 32'h0);

        // R11 pads, R4 data read
        wr(A(0,2), 32'hFFFF_FF00);
        wr(A(0,1), 32'h0000_00A5);
        wr(A(0,0), 32'h0000_000F);
        idle(1);
        chk("R11 pad_oe low byte", {24'h0, pad_oe[7:0]}, 32'hFA);
        chk("R11 pad_out low byte", {24'h0, pad_out[7:0]}, 32'hA0);
        chk("R11 input lines undriven", pad_oe[31:8], 32'h0);
        pins[15:8] = 8'h3C;
        idle(3);
        rd(A(0,1), v); chk("R4 data mixes outputs and pins", v, 32'h0000_3CA5);
        pins[15:8] = 8'h00;
        idle(4);
        rd(A(0,7), v); chk("R6 default falling edges", v, 32'h0000_3C00);
        chk("R9 masked status gives no irq", {31'h0, irq}, 32'h0);
        wr(A(0,7), 32'hFFFF_FFFF); rd(A(0,7), v); chk("R8 clear all", v, 32'h0);
        wr(A(0,2), 32'hFFFF_FFFF);

        // R10 latency, R6 rising
        wr(A(0,3), 32'h0001_0000);
        wr(A(0,5), 32'h0001_0000);
        @(negedge clk); #1; pins[16] = 1'b1;
        idle(1); chk("R10 edge1 no irq", {31'h0, irq}, 32'h0);
        idle(1); chk("R10 edge2 no irq", {31'h0, irq}, 32'h0);
        idle(1); chk("R10 edge3 irq", {31'h0, irq}, 32'h1);
        wr(A(0,7), 32'h0); rd(A(0,7), v); chk("R8 zero write keeps", v, 32'h0001_0000);
        wr(A(0,7), 32'h0001_0000);
        chk("R8 clear drops irq", {31'h0, irq}, 32'h0);
        pins[16] = 1'b0; idle(4);
        rd(A(0,7), v); chk("R6 rising line ignores fall", v, 32'h0);

        // R6 falling
        pins[17] = 1'b1; idle(4); pins[17] = 1'b0; idle(4);
        rd(A(0,7), v); chk("R6 falling line", v, 32'h0002_0000);
        wr(A(0,7), 32'hFFFF_FFFF);

        // R7 both edges
        wr(A(0,4), 32'h0004_0000);
        wr(A(0,3), 32'h0005_0000);
        pins[18] = 1'b1; idle(4);
        rd(A(0,7), v); chk("R7 both edges rise", v, 32'h0004_0000);
        wr(A(0,7), 32'hFFFF_FFFF);
        pins[18] = 1'b0; idle(4);
        rd(A(0,7), v); chk("R7 both edges fall", v, 32'h0004_0000);
        wr(A(0,7), 32'hFFFF_FFFF);

        // R5 level high
        wr(A(0,3), 32'h0015_0000);
        wr(A(0,6), 32'h0010_0000);
        pins[20] = 1'b1; idle(4);
        wr(A(0,7), 32'hFFFF_FFFF);
        rd(A(0,7), v); chk("R5 clear while level holds", v, 32'h0010_0000);
        pins[20] = 1'b0; idle(4);
        wr(A(0,7), 32'hFFFF_FFFF);
        rd(A(0,7), v); chk("R5 clear after level ends", v, 32'h0);

        // R5 level low
        wr(A(0,6), 32'h0030_0000);
        idle(2);
        rd(A(0,7), v); chk("R5 active-low level", v, 32'h0020_0000);
        pins[21] = 1'b1; idle(4);
        wr(A(0,7), 32'hFFFF_FFFF);
        rd(A(0,7), v); chk("R5 low level released", v, 32'h0);

        // R9 across banks, R3 unused lines
        wr(A(2,5), 32'h8);
        pins[67] = 1'b1; idle(4); pins[67] = 1'b0; idle(4);
        chk("R9 bank2 raises irq", {31'h0, irq}, 32'h1);
        rd(A(2,7), v); chk("R9 bank2 status", v, 32'h8);
        pins[84] = 1'b1; idle(4); pins[84] = 1'b0; idle(4);
        rd(A(2,7), v); chk("R3 line above width ignored", v, 32'h8);
        pins[37] = 1'b1; idle(4); pins[37] = 1'b0; idle(4);
        rd(A(1,7), v); chk("R3 empty bank ignores pins", v, 32'h0);
        wr(A(2,7), 32'hFFFF_FFFF);
        chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);

        // R9 mask gating
        pins[17] = 1'b1; idle(4); pins[17] = 1'b0; idle(4);
        chk("R9 masked line no irq", {31'h0, irq}, 32'h0);
        rd(A(0,7), v); chk("R9 masked line still latches", v, 32'h0002_0000);
        wr(A(0,5), 32'h0003_0000);
        chk("R9 unmask raises irq", {31'h0, irq}, 32'h1);

        // R2 reset mid-run
        @(negedge clk); #1; rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk("R2 irq after second reset", {31'h0, irq}, 32'h0);
        rd(A(0,7), v); chk("R2 status after second reset", v, 32'h0);
        rd(A(2,2), v); chk("R2 direction after second reset", v, 32'h0000_0FFF);

        idle(2);
        finish_run();
    end

endmodule